// File: doc/BRIEF.md
# I2C Target Transmit Engine with Request Flags

This block is the read-data side of an I2C target. It watches synchronised SCL and SDA, recognises a START, collects the 7-bit address and the direction bit, and acknowledges when the address is its own or, if enabled, an alternate identifier. On a read it takes bytes from a small transmit FIFO and shifts them out MSB first through an open-drain SDA pull-down. It continues until the controller answers a byte with NACK, and ends the transfer on STOP.

Software keeps the FIFO fed by polling three status flags: a transmit request, an underflow flag and a FIFO-status/early-request flag. A configuration bit selects when the first request appears. In normal timing it appears on the falling SCL edge that ends the direction-bit pulse. In early timing it appears just after the rising edge of that pulse, and a one-shot early flag fires once per read transfer. A small register port writes transmit bytes, reads the status (which clears the flags), and sets the configuration and the alternate identifier.

Top module: `i2c_tgt_tx`

## Requirements
- R1: The byte after START carries 7 address bits MSB first, then the direction bit (1 = read). The target pulls SDA low during the 9th clock only if the address equals config bits [6:0], or equals ALT register bits [6:0] while config bit 8 (alternate enable) is 1. Otherwise it never drives SDA.
- R2: With config bit 7 clear (normal timing), status bit 0 (transmit request) stays 0 through the high phase of the direction bit. It becomes 1 after the falling SCL edge that ends that bit, and only for a matching read.
- R3: With config bit 7 set (early timing), status bit 0 becomes 1 during the high phase of the direction bit of a matching read.
- R4: While a matched read transfer is active and the FIFO is not full, status bit 0 is held at 1 even across status reads. Outside that condition, reading the status register (address 1) clears it. A set in the same cycle as a clearing read wins.
- R5: Writing address 0 pushes the low byte into a FIFO_DEPTH-entry transmit FIFO. A write while the FIFO is full is ignored.
- R6: Each read byte is driven MSB first, with a new bit after each falling SCL edge. SDA is released for the controller's acknowledge. ACK (SDA low at the rising edge) starts the next byte and NACK ends the sending. A byte needed while the FIFO is empty goes out as all ones.
- R7: Status bit 1 (underflow) sets when a byte is needed and the FIFO is empty. A byte is needed at the rising SCL edge of the address acknowledge clock of a read, or of a controller ACK. A status read clears the bit.
- R8: With normal timing, status bit 2 equals "transmit FIFO empty". It is 1 after reset.
- R9: With early timing, status bit 2 sets at the rising edge of the direction bit of a matching read. It clears on a status read and does not set again before a STOP.
- R10: A STOP (SDA rising while SCL is high) ends the read transfer. After that, status bit 0 is no longer held and one status read clears it.
- R11: Address 0 reads 0. Address 2 reads config {alt enable, early, own address}. Address 3 reads the ALT byte in bits [7:0]. All bits above each field read 0.
- R12: After reset the status reads 0x0004, the own address equals DEFAULT_ADDR, and SDA is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears flags) |
| reg_addr | input | 2 | 0 transmit data, 1 status, 2 config, 3 alternate ID |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |

## Verification
The bench builds the block with its defaults: 7-bit address, 8-bit data, a 2-entry FIFO, two synchroniser stages, alternate matching compiled in and own address 0x3A. The FIFO holds only two bytes and every read transfer asks for three. Every pass therefore reaches the all-ones filler and the underflow flag, and the 0, 1 and 2 preloads cover the request held versus cleared at a full FIFO. The sweep crosses both timing modes, four address cases (own, alternate enabled, alternate disabled, foreign) and both directions, and checks the flags at the direction-bit rising edge, at its falling edge, after the acknowledge and after STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   // register port addresses
   localparam logic [1:0] REG_TXD  = 2'd0;
   localparam logic [1:0] REG_STAT = 2'd1;
   localparam logic [1:0] REG_CFG  = 2'd2;
   localparam logic [1:0] REG_ALT  = 2'd3;

   // status word bit positions
   localparam int unsigned STAT_TXREQ = 0;
   localparam int unsigned STAT_UFLOW = 1;
   localparam int unsigned STAT_FSE   = 2;

   typedef enum logic [2:0] {
      LK_IDLE,
      LK_ADDR,
      LK_AACK,
      LK_TX,
      LK_MACK,
      LK_WAIT
   } link_st_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;   // bus idles high
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/i2c_tgt_txfifo.sv
module i2c_tgt_txfifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full
);

   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("i2c_tgt_txfifo: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;   // write to a full FIFO is dropped
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R5: a rejected write leaves the fill level untouched
   a_r5_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> full);

   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

endmodule

// File: rtl/i2c_tgt_link.sv
module i2c_tgt_link
   import i2c_tgt_pkg::*;
#(
   parameter int unsigned AW        = 7,
   parameter int unsigned BW        = 8,
   parameter bit          ALT_MATCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl,
   input  logic          sda,
   input  logic [AW-1:0] own_addr,
   input  logic [AW-1:0] alt_id,
   input  logic          alt_en,
   input  logic          fifo_empty,
   input  logic [BW-1:0] fifo_rdata,
   output logic          sda_oe,
   output logic          fifo_pop,
   output logic          dir_rise_hit,
   output logic          dir_fall_hit,
   output logic          need_byte,
   output logic          xfer_active,
   output logic          stop_seen
);

   localparam int unsigned CNTW = $clog2(BW + 1);
   localparam logic [CNTW-1:0] DIR_IDX = CNTW'(BW - 1);
   localparam logic [CNTW-1:0] ACK_IDX = CNTW'(BW);

   if (AW + 1 != BW) begin : g_bad_width
      $error("i2c_tgt_link: address plus direction must fill one byte");
   end

   link_st_e        st;
   logic            scl_q, sda_q;
   logic            scl_rise, scl_fall, start_det, stop_det;
   logic [AW-1:0]   sh;
   logic [BW-1:0]   tx;
   logic [CNTW-1:0] cnt;
   logic            hit_q, rd_q, mack_q, ack_drv;
   logic            own_hit, alt_hit, addr_hit;

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
   assign stop_seen = stop_det;

   // address compare on the 7 bits shifted in before the direction bit
   assign own_hit = (sh == own_addr);

   if (ALT_MATCH) begin : g_alt
      assign alt_hit = alt_en && (sh == alt_id);
   end else begin : g_no_alt
      logic alt_unused;
      assign alt_unused = alt_en ^ (^alt_id);
      assign alt_hit    = 1'b0;
   end

   assign addr_hit = own_hit | alt_hit;

   // open-drain drive: address ACK, or a zero data bit while sending
   assign sda_oe = ack_drv | ((st == LK_TX) & ~tx[BW-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= LK_IDLE;
         sh           <= '0;
         tx           <= '1;
         cnt          <= '0;
         hit_q        <= 1'b0;
         rd_q         <= 1'b0;
         mack_q       <= 1'b0;
         ack_drv      <= 1'b0;
         xfer_active  <= 1'b0;
         fifo_pop     <= 1'b0;
         dir_rise_hit <= 1'b0;
         dir_fall_hit <= 1'b0;
         need_byte    <= 1'b0;
      end else begin
         fifo_pop     <= 1'b0;
         dir_rise_hit <= 1'b0;
         dir_fall_hit <= 1'b0;
         need_byte    <= 1'b0;
         if (stop_det) begin
            st          <= LK_IDLE;
            ack_drv     <= 1'b0;
            xfer_active <= 1'b0;
         end else if (start_det) begin
            st          <= LK_ADDR;
            cnt         <= '0;
            ack_drv     <= 1'b0;
            xfer_active <= 1'b0;
         end else begin
            unique case (st)
               LK_IDLE: ;
               LK_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[AW-2:0], sda};
                     cnt <= cnt + 1'b1;
                     if (cnt == DIR_IDX) begin
                        hit_q <= addr_hit;
                        rd_q  <= sda;
                        if (addr_hit && sda) dir_rise_hit <= 1'b1;
                     end
                  end else if (scl_fall && cnt == ACK_IDX) begin
                     if (hit_q) begin
                        st      <= LK_AACK;
                        ack_drv <= 1'b1;
                        if (rd_q) begin
                           dir_fall_hit <= 1'b1;
                           xfer_active  <= 1'b1;
                        end
                     end else begin
                        st <= LK_WAIT;
                     end
                  end
               end
               LK_AACK: begin
                  if (scl_rise) begin
                     if (rd_q) need_byte <= 1'b1;
                  end else if (scl_fall) begin
                     ack_drv <= 1'b0;
                     if (rd_q) begin
                        tx       <= fifo_empty ? '1 : fifo_rdata;
                        fifo_pop <= !fifo_empty;
                        cnt      <= '0;
                        st       <= LK_TX;
                     end else begin
                        st <= LK_WAIT;
                     end
                  end
               end
               LK_TX: begin
                  if (scl_fall) begin
                     if (cnt == DIR_IDX) begin
                        st <= LK_MACK;          // release for controller ACK
                     end else begin
                        tx  <= {tx[BW-2:0], 1'b1};
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               LK_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda;
                     if (!sda) need_byte <= 1'b1;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx       <= fifo_empty ? '1 : fifo_rdata;
                        fifo_pop <= !fifo_empty;
                        cnt      <= '0;
                        st       <= LK_TX;
                     end else begin
                        st <= LK_WAIT;
                     end
                  end
               end
               LK_WAIT: ;
               default: st <= LK_IDLE;
            endcase
         end
      end
   end

   // R1: an idle target leaves the line alone
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_IDLE) |-> !sda_oe);

   // R6: the controller acknowledge slot is never driven by the target
   a_r6_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_MACK) |-> !sda_oe);

   // R10: STOP terminates the read transfer
   a_r10_stop_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !xfer_active);

endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx
   import i2c_tgt_pkg::*;
#(
   parameter int unsigned           ADDR_W       = 7,
   parameter int unsigned           DATA_W       = 8,
   parameter int unsigned           FIFO_DEPTH   = 2,
   parameter int unsigned           SYNC_STAGES  = 2,
   parameter int unsigned           REG_W        = 16,
   parameter bit                    ALT_MATCH    = 1'b1,
   parameter logic [ADDR_W-1:0]     DEFAULT_ADDR = 7'h3A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata
);

   localparam int unsigned CFG_EARLY = ADDR_W;
   localparam int unsigned CFG_ALTEN = ADDR_W + 1;

   if (DATA_W != ADDR_W + 1) begin : g_bad_data_w
      $error("i2c_tgt_tx: DATA_W must equal ADDR_W + 1");
   end
   if (REG_W < CFG_ALTEN + 1 || REG_W < DATA_W || REG_W < 3) begin : g_bad_reg_w
      $error("i2c_tgt_tx: REG_W too narrow for the register fields");
   end

   logic [1:0]        sync_q;
   logic              scl_s, sda_s;
   logic [ADDR_W-1:0] own_q;
   logic [DATA_W-1:0] alt_q;
   logic              early_q, alt_en_q;
   logic              txreq_q, uf_q, fse_q, arm_q;
   logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
   logic [DATA_W-1:0] fifo_rdata;
   logic              dir_rise_hit, dir_fall_hit, need_byte, xfer_active, stop_seen;
   logic              stat_rd, txreq_set, uf_set, fse_set;
   logic              wdata_unused;

   assign wdata_unused = ^reg_wdata;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (sync_q)
   );
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   assign fifo_push = reg_wr && (reg_addr == REG_TXD);

   i2c_tgt_txfifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .wdata (reg_wdata[DATA_W-1:0]),
      .pop   (fifo_pop),
      .rdata (fifo_rdata),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   i2c_tgt_link #(.AW(ADDR_W), .BW(DATA_W), .ALT_MATCH(ALT_MATCH)) u_link (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl          (scl_s),
      .sda          (sda_s),
      .own_addr     (own_q),
      .alt_id       (alt_q[ADDR_W-1:0]),
      .alt_en       (alt_en_q),
      .fifo_empty   (fifo_empty),
      .fifo_rdata   (fifo_rdata),
      .sda_oe       (sda_oe),
      .fifo_pop     (fifo_pop),
      .dir_rise_hit (dir_rise_hit),
      .dir_fall_hit (dir_fall_hit),
      .need_byte    (need_byte),
      .xfer_active  (xfer_active),
      .stop_seen    (stop_seen)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q    <= DEFAULT_ADDR;
         early_q  <= 1'b0;
         alt_en_q <= 1'b0;
         alt_q    <= '0;
      end else if (reg_wr) begin
         if (reg_addr == REG_CFG) begin
            own_q    <= reg_wdata[ADDR_W-1:0];
            early_q  <= reg_wdata[CFG_EARLY];
            alt_en_q <= reg_wdata[CFG_ALTEN];
         end
         if (reg_addr == REG_ALT) alt_q <= reg_wdata[DATA_W-1:0];
      end
   end

   // status flags: a hardware set beats a clearing read in the same cycle
   assign stat_rd   = reg_rd && (reg_addr == REG_STAT);
   assign txreq_set = (early_q ? dir_rise_hit : dir_fall_hit) | (xfer_active & ~fifo_full);
   assign uf_set    = need_byte & fifo_empty;
   assign fse_set   = dir_rise_hit & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txreq_q <= 1'b0;
         uf_q    <= 1'b0;
         fse_q   <= 1'b1;
         arm_q   <= 1'b1;
      end else begin
         txreq_q <= txreq_set | (txreq_q & ~stat_rd);
         uf_q    <= uf_set | (uf_q & ~stat_rd);
         if (early_q) fse_q <= fse_set | (fse_q & ~stat_rd);
         else         fse_q <= fifo_empty;
         if (stop_seen)              arm_q <= 1'b1;
         else if (early_q && fse_set) arm_q <= 1'b0;
      end
   end

   // register read mux
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         REG_TXD: reg_rdata = '0;
         REG_STAT: begin
            reg_rdata[STAT_TXREQ] = txreq_q;
            reg_rdata[STAT_UFLOW] = uf_q;
            reg_rdata[STAT_FSE]   = fse_q;
         end
         REG_CFG: begin
            reg_rdata[ADDR_W-1:0] = own_q;
            reg_rdata[CFG_EARLY]  = early_q;
            reg_rdata[CFG_ALTEN]  = alt_en_q;
         end
         REG_ALT: reg_rdata[DATA_W-1:0] = alt_q;
         default: reg_rdata = '0;
      endcase
   end

   // R4: request is held while the read is live and there is room
   a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && !fifo_full) |=> txreq_q);

   // R7: an empty FIFO at a byte demand raises underflow
   a_r7_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      (need_byte && fifo_empty) |=> uf_q);

   // R8: normal timing mirrors the FIFO empty state
   a_r8_fse_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      !early_q |=> (fse_q == $past(fifo_empty)));

   // R9: armed early request raises the flag
   a_r9_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (early_q && dir_rise_hit && arm_q) |=> fse_q);

endmodule

// File: tb/sim_i2c_tgt_tx.sv
`timescale 1ns/1ps
module sim_i2c_tgt_tx;

   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_bus;
   logic        sda_oe;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;

   int vectors = 0;
   int errors  = 0;
   logic [7:0] model_q[$];
   int seq = 0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_tgt_tx #(.DEFAULT_ADDR(7'h3A)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wt();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1;
      reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;
      wt();
      scl_m = 1'b1;
      wt();
      scl_m = 1'b0;
   endtask

   task automatic recv_byte(output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1;
         wt();
         scl_m = 1'b1;
         wt();
         b[i] = sda_bus;
         scl_m = 1'b0;
      end
   endtask

   task automatic bus_start();
      scl_m = 1'b1;
      sda_m = 1'b1;
      wt();
      sda_m = 1'b0;
      wt();
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;
      wt();
      scl_m = 1'b1;
      wt();
      sda_m = 1'b1;
      wt();
   endtask

   function automatic logic [15:0] stat(input logic t, input logic u, input logic f);
      return {13'b0, f, u, t};
   endfunction

   function automatic logic [7:0] take_byte();
      if (model_q.size() == 0) return 8'hFF;
      return model_q.pop_front();
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      vectors++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [7:0]  b, exp_b, addr;
      logic        match, empty0, full0, uf_acc;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R12 reset state
      chk("R12 sda_oe after reset", {15'b0, sda_oe}, 16'h0000);
      rd(2'd1, d); chk("R12 status after reset", d, 16'h0004);
      rd(2'd2, d); chk("R12 R11 config after reset", d, 16'h003A);
      // R11 register reads
      rd(2'd0, d); chk("R11 transmit address reads zero", d, 16'h0000);
      wr(2'd3, 16'hFF55);
      rd(2'd3, d); chk("R11 alt id readback", d, 16'h0055);
      wr(2'd2, 16'h01BA);
      rd(2'd2, d); chk("R11 config readback", d, 16'h01BA);

      for (int e = 0; e < 2; e++) begin
         for (int k = 0; k < 4; k++) begin
            for (int dir = 0; dir < 2; dir++) begin
               for (int f = 0; f < 3; f++) begin
                  wr(2'd2, {7'b0, (k == 1), e[0], 7'h3A});
                  for (int i = 0; i < f; i++) begin
                     b = 8'(seq * 29 + 3);
                     seq++;
                     wr(2'd0, {8'hC3, b});                 // R5 push, upper byte ignored
                     if (model_q.size() < 2) model_q.push_back(b);
                  end
                  rd(2'd1, d);                               // clear leftover flags
                  case (k)
                     0: addr = {7'h3A, dir[0]};
                     1: addr = {7'h55, dir[0]};
                     2: addr = {7'h55, dir[0]};
                     default: addr = {7'h11, dir[0]};
                  endcase
                  match  = (k <= 1);
                  empty0 = (model_q.size() == 0);
                  full0  = (model_q.size() == 2);

                  bus_start();
                  for (int i = 7; i >= 1; i--) send_bit(addr[i]);
                  // direction bit, high phase
                  sda_m = dir[0];
                  wt();
                  scl_m = 1'b1;
                  wt();
                  rd(2'd1, d);
                  chk("R3 R9 status at direction rising edge", d,
                      stat(match && dir && e, 1'b0, e ? (match && dir) : empty0));
                  scl_m = 1'b0;
                  wt();
                  rd(2'd1, d);
                  chk("R2 R4 status after direction falling edge", d,
                      stat(match && dir && (!e || !full0), 1'b0, e ? 1'b0 : empty0));
                  // acknowledge clock
                  sda_m = 1'b1;
                  wt();
                  scl_m = 1'b1;
                  wt();
                  chk("R1 address acknowledge", {15'b0, sda_bus}, {15'b0, !match});
                  scl_m = 1'b0;
                  wt();

                  uf_acc = 1'b0;
                  if (match && dir) begin
                     exp_b = take_byte();
                     rd(2'd1, d);
                     chk("R7 R4 status after address acknowledge", d,
                         stat(1'b1, empty0, e ? 1'b0 : (model_q.size() == 0)));
                     for (int j = 0; j < 3; j++) begin
                        recv_byte(b);
                        chk("R6 R5 serial byte", {8'h00, b}, {8'h00, exp_b});
                        send_bit(j == 2);                    // ACK, ACK, then NACK
                        if (j < 2) begin
                           if (model_q.size() == 0) uf_acc = 1'b1;
                           exp_b = take_byte();
                        end
                     end
                  end else begin
                     chk("R1 line free after acknowledge slot", {15'b0, sda_oe}, 16'h0000);
                  end
                  wt();
                  bus_stop();
                  rd(2'd1, d);
                  chk("R10 R7 R8 status after stop", d,
                      stat(match && dir, uf_acc, e ? 1'b0 : (model_q.size() == 0)));
                  rd(2'd1, d);
                  chk("R10 request cleared after stop", d,
                      stat(1'b0, 1'b0, e ? 1'b0 : (model_q.size() == 0)));
               end
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule